// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a synchronous DRAM. On every rising clock edge it samples the clock-enable, the three active-low row, column and write strobes, the two bank-select bits and the address bus. It turns each sampled combination into one of six events: activate, read, write, mode set, precharge or no-op. Each event appears as a one-cycle pulse in the cycle after the edge that sampled it.

The block keeps a record of which of the four banks holds an open row and which row that is. It runs a per-bank down-counter that enforces the row-to-column delay `TRCD`. It also holds a decoded mode register with four fields: burst length code, burst ordering, CAS latency and single-write mode.

A command that breaks a timing or state rule is refused and reported on a dedicated error pulse instead of its event. Three cases are refused:

- a column command before the delay has run out, or to a closed bank;
- a mode set while any bank is open, or without clock-enable high on the edge before it;
- a mode set that carries an unsupported field code.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset all banks are closed, every row record is zero, all event and error outputs are low, and the mode register reads burst code 000, sequential ordering (0), CAS latency 3 and single-write off.
- R2: With `cke` high at an edge, the strobes {rasN,casN,weN} decode as follows, and each yields a one-cycle pulse in the cycle after the edge:
  - 011 is activate;
  - 101 is read;
  - 100 is write;
  - 000 is mode set;
  - 110 is precharge;
  - 111, 001 and 010 are no-op.
  At most one event or error output is high in any cycle.
- R3: An edge at which `cke` is low produces no event or error pulse and changes no bank or mode state; delay counters keep counting.
- R4: An activate opens the bank chosen by `bankSel` and records `addr` as that bank's row on `rowOf[b*ADDR_W +: ADDR_W]`. An activate to an already open bank reopens it with the new row.
- R5: A precharge with `addr[10]`=1 closes all banks. With `addr[10]`=0 it closes only the bank on `bankSel`.
- R6: A read or write to a bank that is closed, or that was activated fewer than `TRCD` edges earlier, gives `errColumn` instead of `evRead`/`evWrite`. At exactly `TRCD` edges after the activate the command is accepted.
- R7: An accepted mode set pulses `evMode` and loads four fields from `addr`:
  - `addr[2:0]` is the burst code (000=1, 001=2, 010=4, 011=8, 111=full page);
  - `addr[3]` is the ordering (1=interleave);
  - `addr[6:4]` is the CAS latency;
  - `addr[9]` is single-write.

  All other address bits are ignored.
- R8: A mode set while any bank is open, or when `cke` was low at the previous edge, gives `errModePre` and leaves the mode register unchanged. This check takes precedence over R9.
- R9: A mode set whose preconditions hold but whose code is unsupported gives `errModeCode` and leaves the mode register unchanged. Unsupported codes are a burst code of 100, 101 or 110, a CAS latency other than 2 or 3, or full page with interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suppresses command decode |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| bankSel | input | 2 | Bank select |
| addr | input | ADDR_W | Row address, mode fields, precharge-all bit 10 |
| evAct | output | 1 | Activate accepted |
| evRead | output | 1 | Read accepted |
| evWrite | output | 1 | Write accepted |
| evMode | output | 1 | Mode set accepted |
| evPre | output | 1 | Precharge decoded |
| evNop | output | 1 | No-op decoded |
| errColumn | output | 1 | Column command refused |
| errModePre | output | 1 | Mode set refused, precondition |
| errModeCode | output | 1 | Mode set refused, bad code |
| bankOpen | output | 4 | Open flag per bank |
| rowOf | output | 4*ADDR_W | Row held by each bank, bank 0 in the low bits |
| modeBurstLen | output | 3 | Burst length code |
| modeInterleave | output | 1 | Burst ordering, 1 = interleave |
| modeCasLat | output | 3 | CAS latency |
| modeSingleWrite | output | 1 | Burst-read single-write mode |

## Verification
Two pairs of functions can meet at one edge. The first pair is the per-bank delay counter expiring while a column command tests it. The second pair is the bank-state update from a precharge-all while the very next edge tests mode-set legality. Both are provoked directly with read at one and at exactly `TRCD` edges after an activate, and with a mode set on the edge right after a precharge-all, right after a single-bank precharge that leaves another bank open, and right after an edge with `cke` low. Random mixes of all strobe codes, bank numbers and addresses create further collisions. A bench model updated from the requirements at each edge judges every output group in every cycle.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  localparam int BANKS  = 4;
  localparam int BANK_W = 2;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_READ, CMD_WRITE, CMD_MODE, CMD_PRE
  } cmd_e;

  typedef struct packed {
    logic doAct;
    logic doPre;
    logic preAll;
    logic doMode;
    logic [BANK_W-1:0] bank;
  } trkStrobe_t;

  typedef struct packed {
    logic [2:0] burstLen;
    logic       interleave;
    logic [2:0] casLat;
    logic       singleWrite;
  } modeReg_t;
endpackage

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic [BANK_W-1:0] bankSel,
  input  logic             preAllBit,
  input  logic [6:0]       modeBits,
  input  logic [BANKS-1:0] bankOpen,
  input  logic [BANKS-1:0] bankReady,
  output trkStrobe_t       strb,
  output logic             evAct,
  output logic             evRead,
  output logic             evWrite,
  output logic             evMode,
  output logic             evPre,
  output logic             evNop,
  output logic             errColumn,
  output logic             errModePre,
  output logic             errModeCode
);
  cmd_e cmd;
  logic ckePrev;
  logic isCol, colOk, modePreOk, codeOk;

  always_comb begin
    case ({rasN, casN, weN})
      3'b011:  cmd = CMD_ACT;
      3'b101:  cmd = CMD_READ;
      3'b100:  cmd = CMD_WRITE;
      3'b000:  cmd = CMD_MODE;
      3'b110:  cmd = CMD_PRE;
      default: cmd = CMD_NOP;
    endcase
  end

  always_comb begin
    logic [2:0] bl;
    logic [2:0] cl;
    bl = modeBits[2:0];
    cl = modeBits[6:4];
    codeOk = (bl inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7}) &&
             (cl inside {3'd2, 3'd3}) &&
             !(bl == 3'd7 && modeBits[3]);
  end

  assign isCol     = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign colOk     = bankOpen[bankSel] && bankReady[bankSel];
  assign modePreOk = ckePrev && (bankOpen == '0);

  assign strb.doAct  = cke && (cmd == CMD_ACT);
  assign strb.doPre  = cke && (cmd == CMD_PRE);
  assign strb.preAll = preAllBit;
  assign strb.doMode = cke && (cmd == CMD_MODE) && modePreOk && codeOk;
  assign strb.bank   = bankSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckePrev     <= 1'b0;
      evAct       <= 1'b0;
      evRead      <= 1'b0;
      evWrite     <= 1'b0;
      evMode      <= 1'b0;
      evPre       <= 1'b0;
      evNop       <= 1'b0;
      errColumn   <= 1'b0;
      errModePre  <= 1'b0;
      errModeCode <= 1'b0;
    end else begin
      ckePrev     <= cke;
      evAct       <= strb.doAct;
      evRead      <= cke && (cmd == CMD_READ) && colOk;
      evWrite     <= cke && (cmd == CMD_WRITE) && colOk;
      evMode      <= strb.doMode;
      evPre       <= strb.doPre;
      evNop       <= cke && (cmd == CMD_NOP);
      errColumn   <= cke && isCol && !colOk;
      errModePre  <= cke && (cmd == CMD_MODE) && !modePreOk;
      errModeCode <= cke && (cmd == CMD_MODE) && modePreOk && !codeOk;
    end
  end

  AST_EVENT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evAct, evRead, evWrite, evMode, evPre, evNop,
              errColumn, errModePre, errModeCode})); // R2

  AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> !(evAct | evRead | evWrite | evMode | evPre | evNop |
               errColumn | errModePre | errModeCode)); // R3

  AST_COL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && isCol && !bankOpen[bankSel]) |=> (errColumn && !evRead && !evWrite)); // R6
endmodule

// File: rtl/sdram_trk_dp.sv
module sdram_trk_dp
  import sdram_trk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int TRCD   = 2
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  trkStrobe_t             strb,
  input  logic [ADDR_W-1:0]      addr,
  output logic [BANKS-1:0]       bankOpen,
  output logic [BANKS-1:0]       bankReady,
  output logic [BANKS*ADDR_W-1:0] rowOf,
  output modeReg_t               modeReg
);
  localparam int CNT_W = (TRCD < 2) ? 1 : $clog2(TRCD + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRCD - 1);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] row;
    logic actHit, preHit;

    assign actHit = strb.doAct && (strb.bank == BANK_W'(b));
    assign preHit = strb.doPre && (strb.preAll || strb.bank == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt         <= '0;
        row         <= '0;
        bankOpen[b] <= 1'b0;
      end else if (actHit) begin
        cnt         <= CNT_LOAD;
        row         <= addr;
        bankOpen[b] <= 1'b1;
      end else if (preHit) begin
        cnt         <= '0;
        bankOpen[b] <= 1'b0;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign bankReady[b] = (cnt == '0);
    assign rowOf[b*ADDR_W +: ADDR_W] = row;

    AST_CNT_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> bankOpen[b]); // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeReg <= '{burstLen: 3'd0, interleave: 1'b0, casLat: 3'd3, singleWrite: 1'b0};
    end else if (strb.doMode) begin
      modeReg <= '{burstLen: addr[2:0], interleave: addr[3],
                   casLat: addr[6:4], singleWrite: addr[9]};
    end
  end

  AST_MODE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (modeReg != $past(modeReg)) |-> ($past(bankOpen) == '0)); // R8

  AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doPre && strb.preAll) |=> (bankOpen == '0)); // R5

  AST_CL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (modeReg.casLat == 3'd2) || (modeReg.casLat == 3'd3)); // R9

  AST_BL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (modeReg.burstLen inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7}) &&
    !(modeReg.burstLen == 3'd7 && modeReg.interleave)); // R9
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int TRCD   = 2
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    rasN,
  input  logic                    casN,
  input  logic                    weN,
  input  logic [1:0]              bankSel,
  input  logic [ADDR_W-1:0]       addr,
  output logic                    evAct,
  output logic                    evRead,
  output logic                    evWrite,
  output logic                    evMode,
  output logic                    evPre,
  output logic                    evNop,
  output logic                    errColumn,
  output logic                    errModePre,
  output logic                    errModeCode,
  output logic [3:0]              bankOpen,
  output logic [4*ADDR_W-1:0]     rowOf,
  output logic [2:0]              modeBurstLen,
  output logic                    modeInterleave,
  output logic [2:0]              modeCasLat,
  output logic                    modeSingleWrite
);
  trkStrobe_t       strb;
  logic [BANKS-1:0] bankReady;
  modeReg_t         modeReg;

  sdram_trk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .rasN(rasN), .casN(casN), .weN(weN),
    .bankSel(bankSel), .preAllBit(addr[10]), .modeBits(addr[6:0]),
    .bankOpen(bankOpen), .bankReady(bankReady), .strb(strb),
    .evAct(evAct), .evRead(evRead), .evWrite(evWrite), .evMode(evMode),
    .evPre(evPre), .evNop(evNop), .errColumn(errColumn),
    .errModePre(errModePre), .errModeCode(errModeCode)
  );

  sdram_trk_dp #(.ADDR_W(ADDR_W), .TRCD(TRCD)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .addr(addr),
    .bankOpen(bankOpen), .bankReady(bankReady), .rowOf(rowOf),
    .modeReg(modeReg)
  );

  assign modeBurstLen    = modeReg.burstLen;
  assign modeInterleave  = modeReg.interleave;
  assign modeCasLat      = modeReg.casLat;
  assign modeSingleWrite = modeReg.singleWrite;
endmodule

// File: tb/tb_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module tb_sdram_cmd_tracker;
  localparam int AW = 12;
  localparam int TRCD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] bankSel = '0;
  logic [AW-1:0] addr = '0;
  logic evAct, evRead, evWrite, evMode, evPre, evNop;
  logic errColumn, errModePre, errModeCode;
  logic [3:0] bankOpen;
  logic [4*AW-1:0] rowOf;
  logic [2:0] modeBurstLen, modeCasLat;
  logic modeInterleave, modeSingleWrite;

  sdram_cmd_tracker #(.ADDR_W(AW), .TRCD(TRCD)) dut (.*);

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // bench model
  bit mOpen [4];
  logic [AW-1:0] mRow [4];
  int mCnt [4];
  logic [7:0] mMode;   // {bl[2:0], bt, cl[2:0], sw}
  bit mCkePrev;
  logic [5:0] xEv;     // {act, rd, wr, mode, pre, nop}
  logic [2:0] xErr;    // {column, modePre, modeCode}

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit codeLegal(input logic [AW-1:0] a);
    logic [2:0] bl;
    logic [2:0] cl;
    bl = a[2:0];
    cl = a[6:4];
    if (bl == 3'd4 || bl == 3'd5 || bl == 3'd6) return 0;
    if (cl != 3'd2 && cl != 3'd3) return 0;
    if (bl == 3'd7 && a[3]) return 0;
    return 1;
  endfunction

  task automatic modelReset();
    for (int b = 0; b < 4; b++) begin
      mOpen[b] = 0; mRow[b] = '0; mCnt[b] = 0;
    end
    mMode = {3'd0, 1'b0, 3'd3, 1'b0};
    mCkePrev = 0;
  endtask

  task automatic modelEdge(input logic c, input logic [2:0] rcw, input logic [1:0] bs,
                           input logic [AW-1:0] a);
    bit anyOpen;
    anyOpen = mOpen[0] | mOpen[1] | mOpen[2] | mOpen[3];
    xEv = '0; xErr = '0;
    for (int b = 0; b < 4; b++) if (mCnt[b] > 0) mCnt[b]--;
    if (c) begin
      case (rcw)
        3'b011: begin
          xEv[5] = 1; mOpen[bs] = 1; mRow[bs] = a; mCnt[bs] = TRCD - 1;
        end
        3'b101, 3'b100: begin
          // counter was decremented above; pre-edge value was mCnt+1 when nonzero
          if (mOpen[bs] && mCnt[bs] == 0 && !colBusy[bs]) begin
            if (rcw == 3'b101) xEv[4] = 1; else xEv[3] = 1;
          end else xErr[2] = 1;
        end
        3'b000: begin
          if (!mCkePrev || anyOpen) xErr[1] = 1;
          else if (!codeLegal(a)) xErr[0] = 1;
          else begin
            xEv[2] = 1; mMode = {a[2:0], a[3], a[6:4], a[9]};
          end
        end
        3'b110: begin
          xEv[1] = 1;
          for (int b = 0; b < 4; b++)
            if (a[10] || bs == 2'(b)) begin mOpen[b] = 0; mCnt[b] = 0; end
        end
        default: xEv[0] = 1;
      endcase
    end
    mCkePrev = c;
  endtask

  // pre-edge busy flags, captured before the model's decrement
  bit colBusy [4];

  task automatic step(input logic c, input logic [2:0] rcw, input logic [1:0] bs,
                      input logic [AW-1:0] a);
    logic [4*AW-1:0] xRows;
    for (int b = 0; b < 4; b++) colBusy[b] = (mCnt[b] != 0);
    cke = c; {rasN, casN, weN} = rcw; bankSel = bs; addr = a;
    modelEdge(c, rcw, bs, a);
    @(negedge clk);
    for (int b = 0; b < 4; b++) xRows[b*AW +: AW] = mRow[b];
    check("R2 events", {evAct, evRead, evWrite, evMode, evPre, evNop}, xEv);
    check("R6 errColumn", errColumn, xErr[2]);
    check("R8 errModePre", errModePre, xErr[1]);
    check("R9 errModeCode", errModeCode, xErr[0]);
    check("R5 bankOpen", bankOpen, {mOpen[3], mOpen[2], mOpen[1], mOpen[0]});
    check("R4 rowOf", rowOf, xRows);
    check("R7 mode", {modeBurstLen, modeInterleave, modeCasLat, modeSingleWrite}, mMode);
  endtask

  localparam logic [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100, MRS = 3'b000,
                         PRE = 3'b110, NOP = 3'b111;

  function automatic logic [AW-1:0] modeAddr(input logic [2:0] bl, input bit bt,
                                             input logic [2:0] cl, input bit sw);
    logic [AW-1:0] a;
    a = '0; a[2:0] = bl; a[3] = bt; a[6:4] = cl; a[9] = sw;
    return a;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    modelReset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 events", {evAct, evRead, evWrite, evMode, evPre, evNop,
                        errColumn, errModePre, errModeCode}, '0);
    check("R1 bankOpen", bankOpen, '0);
    check("R1 rowOf", rowOf, '0);
    check("R1 mode", {modeBurstLen, modeInterleave, modeCasLat, modeSingleWrite},
          {3'd0, 1'b0, 3'd3, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);

    // R8: first edge after reset has no prior cke high
    step(1, MRS, 0, modeAddr(3'd3, 1, 3'd2, 1));
    // R7: legal set, burst 8 interleave CL2 single write, spare bits ignored
    step(1, MRS, 0, modeAddr(3'd3, 1, 3'd2, 1) | 12'hD80);
    // R9: full page interleave, CL1, reserved burst code
    step(1, MRS, 0, modeAddr(3'd7, 1, 3'd3, 0));
    step(1, MRS, 0, modeAddr(3'd1, 0, 3'd1, 0));
    step(1, MRS, 0, modeAddr(3'd5, 0, 3'd3, 0));
    step(1, MRS, 0, modeAddr(3'd7, 0, 3'd3, 0));
    // R4/R6: activate, column too early, then exactly at TRCD
    step(1, ACT, 2, 12'hABC);
    step(1, RD, 2, 12'h000);
    step(1, RD, 2, 12'h000);
    step(1, WR, 1, 12'h000);          // closed bank
    step(1, ACT, 1, 12'h123);
    step(1, NOP, 0, 12'h000);
    step(1, WR, 1, 12'h000);
    // R8: mode set with banks open
    step(1, MRS, 0, modeAddr(3'd2, 0, 3'd3, 0));
    // R3: cke low ignores activate and precharge
    step(0, ACT, 0, 12'h777);
    step(0, PRE, 0, 12'h400);
    // R5: single precharge leaves other open, then mode still refused
    step(1, PRE, 2, 12'h000);
    step(1, MRS, 0, modeAddr(3'd2, 0, 3'd3, 0));
    step(1, PRE, 0, 12'h400);
    step(1, MRS, 0, modeAddr(3'd2, 0, 3'd3, 0));
    // R8: mode right after cke low edge
    step(0, NOP, 0, 12'h000);
    step(1, MRS, 0, modeAddr(3'd1, 0, 3'd2, 0));
    step(1, MRS, 0, modeAddr(3'd1, 0, 3'd2, 0));
    // R2 undecoded strobe codes are no-ops
    step(1, 3'b001, 0, 12'h000);
    step(1, 3'b010, 0, 12'h000);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic c;
      logic [2:0] rcw;
      logic [AW-1:0] a;
      r = $urandom_range(0, 99);
      c = ($urandom_range(0, 9) != 0);
      a = AW'($urandom);
      if (r < 20) rcw = ACT;
      else if (r < 40) rcw = RD;
      else if (r < 50) rcw = WR;
      else if (r < 70) begin
        rcw = PRE; a[10] = ($urandom_range(0, 2) == 0);
      end else if (r < 85) begin
        rcw = MRS;
        if ($urandom_range(0, 3) != 0) begin
          logic [2:0] bl;
          bl = 3'($urandom_range(0, 4));
          if (bl == 3'd4) bl = 3'd7;
          a = modeAddr(bl, (bl == 3'd7) ? 1'b0 : 1'($urandom),
                       3'($urandom_range(2, 3)), 1'($urandom));
        end
      end else rcw = 3'($urandom);
      step(c, rcw, 2'($urandom), a);
    end
    summary();
  end
endmodule